// File: doc/BRIEF.md
# Per-Switch Pulse-by-Pulse Overcurrent Guard

This block sits between a PWM generator and the gate drivers of a three-phase inverter that also has a brake switch. It takes one active-low command per switch, a short-circuit comparator flag per switch and a current-limit comparator flag per switch. It returns gated drive enables, an active-low short-circuit fault flag and an active-low current-limit warning. Both comparator flag sets are asynchronous and pass through a two-flop synchronizer before the block uses them.

Each switch has its own sticky short-circuit latch. A short-circuit flag seen while that switch is commanded on sets the latch. The latch then removes the drive from that switch alone and holds it off until the command turns on again (an off-to-on edge). The current-limit warning uses a per-switch latch of its own, which clears on the same edge. Protection therefore acts pulse by pulse, and no global clear is needed. The brake switch is never shut down: its drive always follows its command.

Top module: `pwm_fault_guard`

## Requirements
- R1: While rst_ni is low, every bit of gate_o is 0 and sc_fault_no and cl_warn_no are both 1. Every latch starts clear when reset is released.
- R2: A command bit cmd_n_i[k] at 0 means "switch k on". With no latch set, gate_o[k] equals the inverse of cmd_n_i[k] as sampled at the previous rising clock edge.
- R3: Switch k (not the brake) may be commanded on while sc_flag_i[k] is high. In that case its latch sets three clock edges after the flag is first sampled (two synchronizer flops, then the latch), and gate_o[k] goes to 0 at that same edge. All other gate bits are unaffected.
- R4: sc_fault_no is 0 exactly while at least one short-circuit latch is set, and 1 otherwise.
- R5: A set short-circuit latch on switch k holds gate_o[k] at 0 even after the flag drops. It clears only at the edge that samples an off-to-on transition of cmd_n_i[k] (1 at the previous edge, 0 now). At that edge gate_o[k] returns to 1.
- R6: The brake switch is bit index 6 (BRAKE_IDX). Its sc_flag_i and cl_flag_i bits have no effect: gate_o[6] always follows R2, and neither fault output is asserted by it.
- R7: Switch k (not the brake) may be commanded on while its synchronized cl_flag_i[k] is high. In that case cl_warn_no goes to 0 three edges after the flag is sampled, and the drive is not touched. The warning for that switch clears at its next off-to-on command edge.
- R8: A short-circuit or current-limit flag that is high only while its switch is commanded off sets no latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_n_i | input | N_SW (7) | PWM commands, active low, bit 6 is the brake |
| sc_flag_i | input | N_SW (7) | Short-circuit comparator flags, asynchronous, active high |
| cl_flag_i | input | N_SW (7) | Current-limit comparator flags, asynchronous, active high |
| gate_o | output | N_SW (7) | Gated drive enables, 1 = switch conducting |
| sc_fault_no | output | 1 | Short-circuit fault, active low |
| cl_warn_no | output | 1 | Current-limit warning, active low |

## Verification
The assertions assume that the commands are synchronous to clk_i and stable around each rising edge. Only the comparator flags may change at arbitrary times, because those alone pass through the synchronizer. The bench drives every input on the falling edge. It toggles the commands and the flags from a seeded $urandom source with low toggle rates, so that pulses are long enough for latches to set and clear. It also adds directed cases: a flag during an off command, a brake flag, and a flag that drops before the next command pulse.

// File: rtl/pfg_pkg.sv
package pfg_pkg;
  localparam int unsigned PFG_N_SW      = 7;
  localparam int unsigned PFG_BRAKE_IDX = 6;
  localparam int unsigned PFG_SYNC_LEN  = 2;

  typedef struct packed {
    logic sc;
    logic cl;
  } pfg_flags_t;
endpackage

// File: rtl/pfg_sync.sv
module pfg_sync #(
  parameter int unsigned WIDTH  = 7,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= '0;
      else if (s == 0) stage_q[s] <= d_i;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/pfg_leg_guard.sv
module pfg_leg_guard
  import pfg_pkg::*;
#(
  parameter bit IS_BRAKE = 1'b0
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       on_i,
  input  pfg_flags_t flags_i,
  output logic       gate_o,
  output logic       sc_lat_o,
  output logic       cl_lat_o,
  output logic       start_o
);
  logic on_q, gate_q, sc_lat_q, cl_lat_q;
  logic start, sc_next, cl_next;

  assign start = on_i & ~on_q;

  if (IS_BRAKE) begin : g_brake
    // brake leg: no shutdown, no warning
    assign sc_next = 1'b0;
    assign cl_next = 1'b0;
  end else begin : g_inv
    assign sc_next = start ? 1'b0 : (sc_lat_q | (on_i & flags_i.sc));
    assign cl_next = start ? 1'b0 : (cl_lat_q | (on_i & flags_i.cl));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      on_q     <= 1'b0;
      gate_q   <= 1'b0;
      sc_lat_q <= 1'b0;
      cl_lat_q <= 1'b0;
    end else begin
      on_q     <= on_i;
      gate_q   <= on_i & ~sc_next;
      sc_lat_q <= sc_next;
      cl_lat_q <= cl_next;
    end
  end

  assign gate_o   = gate_q;
  assign sc_lat_o = sc_lat_q;
  assign cl_lat_o = cl_lat_q;
  assign start_o  = start;

  // R3: flag during a running pulse removes drive next cycle
  a_r3_sc_blocks_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!IS_BRAKE && on_i && flags_i.sc && !start) |=> !gate_q);

  // R5: latch drops only on a fresh command pulse
  a_r5_sc_clears_on_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sc_lat_q) |-> $past(start));

  // R8: flags while off set nothing
  a_r8_off_no_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!on_i && !sc_lat_q) |=> !sc_lat_q);
endmodule

// File: rtl/pwm_fault_guard.sv
module pwm_fault_guard
  import pfg_pkg::*;
#(
  parameter int unsigned N_SW      = PFG_N_SW,
  parameter int unsigned BRAKE_IDX = PFG_BRAKE_IDX,
  parameter int unsigned SYNC_LEN  = PFG_SYNC_LEN
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [N_SW-1:0] cmd_n_i,
  input  logic [N_SW-1:0] sc_flag_i,
  input  logic [N_SW-1:0] cl_flag_i,
  output logic [N_SW-1:0] gate_o,
  output logic            sc_fault_no,
  output logic            cl_warn_no
);
  localparam int unsigned FW = 2 * N_SW;

  logic [FW-1:0]   flag_raw, flag_sync;
  logic [N_SW-1:0] sc_s, cl_s, on, sc_lat, cl_lat, start_vec;

  assign flag_raw = {sc_flag_i, cl_flag_i};

  pfg_sync #(.WIDTH(FW), .STAGES(SYNC_LEN)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (flag_raw),
    .q_o    (flag_sync)
  );

  assign sc_s = flag_sync[FW-1:N_SW];
  assign cl_s = flag_sync[N_SW-1:0];
  assign on   = ~cmd_n_i;

  for (genvar k = 0; k < N_SW; k++) begin : g_leg
    pfg_leg_guard #(.IS_BRAKE(k == BRAKE_IDX)) i_leg (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .on_i     (on[k]),
      .flags_i  ('{sc: sc_s[k], cl: cl_s[k]}),
      .gate_o   (gate_o[k]),
      .sc_lat_o (sc_lat[k]),
      .cl_lat_o (cl_lat[k]),
      .start_o  (start_vec[k])
    );
  end

  assign sc_fault_no = ~|sc_lat;
  assign cl_warn_no  = ~|cl_lat;

  logic past_ok_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok_q <= 1'b0;
    else past_ok_q <= 1'b1;
  end

  // R6: brake drive tracks its command one cycle later
  a_r6_brake_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok_q |-> gate_o[BRAKE_IDX] == $past(on[BRAKE_IDX]));

  // R4: fault asserts only from a synchronized short-circuit flag
  a_r4_fault_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sc_fault_no) |-> $past(|sc_s));

  // R7: warning releases only on some command pulse
  a_r7_warn_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cl_warn_no) |-> $past(|start_vec));

  // R1: reset state at the ports
  always_comb begin
    if (!rst_ni) a_r1_reset_idle: assert (gate_o == '0 && sc_fault_no && cl_warn_no);
  end
endmodule

// File: tb/test_pwm_fault_guard.sv
module test_pwm_fault_guard;
  localparam int N = 7;
  localparam int BR = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] cmd_n = '1, sc_f = '0, cl_f = '0;
  logic [N-1:0] gate;
  logic sc_fault_n, cl_warn_n;

  always #2 clk = ~clk;

  pwm_fault_guard i_pwm_fault_guard (
    .clk_i(clk), .rst_ni(rst_n), .cmd_n_i(cmd_n), .sc_flag_i(sc_f),
    .cl_flag_i(cl_f), .gate_o(gate), .sc_fault_no(sc_fault_n), .cl_warn_no(cl_warn_n)
  );

  int errors = 0, checks = 0, cyc = 0;
  bit finished = 1'b0;

  // reference state
  logic [N-1:0] m_sc1, m_sc2, m_cl1, m_cl2, m_onq, m_sc, m_cl, m_gate;

  function automatic logic [N-1:0] nxt_lat(input logic [N-1:0] lat, input logic [N-1:0] on,
                                            input logic [N-1:0] onq, input logic [N-1:0] fl);
    logic [N-1:0] r;
    for (int k = 0; k < N; k++) begin
      if (k == BR) r[k] = 1'b0;
      else if (on[k] && !onq[k]) r[k] = 1'b0;
      else r[k] = lat[k] | (on[k] & fl[k]);
    end
    return r;
  endfunction

  task automatic model_reset();
    m_sc1 = '0; m_sc2 = '0; m_cl1 = '0; m_cl2 = '0;
    m_onq = '0; m_sc = '0; m_cl = '0; m_gate = '0;
  endtask

  task automatic model_step();
    logic [N-1:0] on, scn, cln;
    on  = ~cmd_n;
    scn = nxt_lat(m_sc, on, m_onq, m_sc2);
    cln = nxt_lat(m_cl, on, m_onq, m_cl2);
    m_gate = on & ~scn;
    m_sc = scn; m_cl = cln; m_onq = on;
    m_sc2 = m_sc1; m_sc1 = sc_f;
    m_cl2 = m_cl1; m_cl1 = cl_f;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s cycle %0d actual=%h expected=%h", req, cyc, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    chk({tag, " R2/R3/R5 gate"}, 32'(gate), 32'(m_gate));
    chk({tag, " R4 fault"}, 32'(sc_fault_n), 32'(~|m_sc));
    chk({tag, " R7 warn"}, 32'(cl_warn_n), 32'(~|m_cl));
  endtask

  task automatic cycle(input string tag);
    model_step();
    @(posedge clk);
    @(negedge clk);
    cyc++;
    check_all(tag);
  endtask

  task automatic run(input int n, input string tag);
    for (int i = 0; i < n; i++) cycle(tag);
  endtask

  initial begin
    for (int w = 0; w < 100000; w++) begin
      @(posedge clk);
      if (finished) break;
    end
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    model_reset();
    cmd_n = 7'b0000000;
    sc_f = '1; cl_f = '1;
    repeat (3) @(negedge clk);
    // R1: outputs idle under reset even with commands on and flags high
    chk("R1 gate in reset", 32'(gate), 32'd0);
    chk("R1 fault in reset", 32'(sc_fault_n), 32'd1);
    chk("R1 warn in reset", 32'(cl_warn_n), 32'd1);
    cmd_n = '1; sc_f = '0; cl_f = '0;
    rst_n = 1'b1;
    run(3, "idle");

    // R2: switch 0 on
    cmd_n[0] = 1'b0;
    run(2, "R2 on");
    // R3: short circuit on switch 0, others running
    cmd_n[3] = 1'b0;
    run(2, "R3 pre");
    sc_f[0] = 1'b1;
    run(4, "R3 trip");
    chk("R3 switch0 blocked", 32'(gate[0]), 32'd0);
    chk("R3 switch3 unaffected", 32'(gate[3]), 32'd1);
    chk("R4 fault low", 32'(sc_fault_n), 32'd0);
    // R5: flag drops, latch holds until next pulse
    sc_f[0] = 1'b0;
    run(4, "R5 hold");
    chk("R5 still blocked", 32'(gate[0]), 32'd0);
    cmd_n[0] = 1'b1;
    run(2, "R5 off");
    cmd_n[0] = 1'b0;
    run(1, "R5 restart");
    chk("R5 gate back", 32'(gate[0]), 32'd1);
    chk("R5 fault cleared", 32'(sc_fault_n), 32'd1);
    cmd_n = '1;
    run(2, "idle");

    // R6: brake flags ignored
    cmd_n[BR] = 1'b0;
    sc_f[BR] = 1'b1; cl_f[BR] = 1'b1;
    run(6, "R6 brake");
    chk("R6 brake gate on", 32'(gate[BR]), 32'd1);
    chk("R6 brake no fault", 32'(sc_fault_n), 32'd1);
    chk("R6 brake no warn", 32'(cl_warn_n), 32'd1);
    sc_f = '0; cl_f = '0; cmd_n = '1;
    run(3, "idle");

    // R8: flags while off
    sc_f[2] = 1'b1; cl_f[2] = 1'b1;
    run(5, "R8 off");
    sc_f = '0; cl_f = '0;
    run(3, "R8 settle");
    cmd_n[2] = 1'b0;
    run(1, "R8 on");
    chk("R8 no latch fault", 32'(sc_fault_n), 32'd1);
    chk("R8 gate runs", 32'(gate[2]), 32'd1);
    chk("R8 no latch warn", 32'(cl_warn_n), 32'd1);

    // R7: current limit warning, drive kept
    cl_f[2] = 1'b1;
    run(4, "R7 warn");
    chk("R7 warn low", 32'(cl_warn_n), 32'd0);
    chk("R7 gate kept", 32'(gate[2]), 32'd1);
    cl_f[2] = 1'b0;
    cmd_n[2] = 1'b1;
    run(2, "R7 off");
    chk("R7 warn held", 32'(cl_warn_n), 32'd0);
    cmd_n[2] = 1'b0;
    run(1, "R7 restart");
    chk("R7 warn cleared", 32'(cl_warn_n), 32'd1);
    cmd_n = '1;
    run(2, "idle");

    // random phase
    void'($urandom(32'h5eed_c0de));
    for (int i = 0; i < 4000; i++) begin
      for (int k = 0; k < N; k++) begin
        if ($urandom_range(15) == 0) cmd_n[k] = ~cmd_n[k];
        if ($urandom_range(31) == 0) sc_f[k] = ~sc_f[k];
        if ($urandom_range(23) == 0) cl_f[k] = ~cl_f[k];
      end
      cycle("rand");
    end

    finished = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule